// File: doc/BRIEF.md
# Drive Port Strobe Sequencer

This block produces the active-low read/write strobe for a parallel ATA-style drive port. It counts cycles of a 30 MHz clock, about 33 ns each. Each request names its transfer class: a data-port PIO access or a non-Ultra multiword DMA word. An 8-bit timing register sets the strobe waveform. In compatible timing the block samples the drive's ready line at a programmed point and keeps the strobe asserted until the drive is ready. In fast timing the ready line is ignored, and the two counts give fixed active and inactive strobe widths.

When the strobe deasserts, the block pulses `done` for one cycle. It then holds off the next request until the programmed recovery gap has passed. Each transfer captures its timing settings when it is accepted, so rewriting the register never changes a cycle that is already under way.

Top module: `ide_strobe_timer`

## Requirements
- R1: After reset `strobe_n` is 1, `done` is 0, `req_ready` is 1 and `cfg_rdata` is 0x00. Timing is then compatible, with the 5-clock sample point and the 4-clock recovery.
- R2: The register fields are: bits [1:0] the sample-point code, bits [3:2] the recovery code, bit 4 the fast-timing enable and bit 5 the DMA-only selector. Bits [7:6] always read 0. A write shows on `cfg_rdata` from the clock after `cfg_we`.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `strobe_n` is low from that edge onward. It stays low for at least S cycles, where sample-point code 00/01/10/11 gives S = 5/4/3/2.
- R4: In compatible timing the ready line passes through a two-flop synchroniser. A rise that is present before clock edge n (counted from the accepting edge as edge 0) ends the strobe at edge max(S, n+2). While the line stays low, the strobe stays low.
- R5: In fast timing the strobe is low for exactly S cycles, whatever the ready line does.
- R6: Fast timing applies to a transfer only when bit 4 is 1. It then covers DMA transfers (`req_dma`=1) always, and covers PIO transfers (`req_dma`=0) only when bit 5 is 0.
- R7: After the strobe deasserts, `req_ready` stays 0 for R-1 cycles, so the strobe stays high for at least R cycles. Recovery code 00/01/10/11 gives R = 4/3/2/1. `req_ready` is 0 while the strobe is low.
- R8: `done` is 1 for exactly one cycle: the first cycle in which `strobe_n` is high again after a transfer.
- R9: A transfer uses the register value held just before its accepting edge. A write in the same cycle as the accept, or during the transfer, affects only later transfers.
- R10: `req_valid` while `req_ready` is 0 is ignored. No strobe follows and no `done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 30 MHz timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing register write enable |
| cfg_wdata | input | 8 | Timing register write data |
| cfg_rdata | output | 8 | Timing register read value |
| req_valid | input | 1 | Transfer request |
| req_dma | input | 1 | 1 = multiword DMA, 0 = PIO data port |
| req_ready | output | 1 | Request can be accepted this cycle |
| iordy | input | 1 | Drive ready line, asynchronous |
| strobe_n | output | 1 | Active-low read/write strobe |
| done | output | 1 | One-cycle end-of-strobe pulse |

## Verification
Two events can land on the same edge: a register write and the acceptance of a request. They are forced together by raising `cfg_we` and `req_valid` in the same cycle, both directed and at random. The strobe width and recovery gap of that transfer must follow the old register value, and the next transfer must follow the new one. Writes in the middle of a strobe are judged the same way. A request raised during recovery must produce no strobe.

// File: rtl/ide_strobe_timer.sv
module ide_strobe_timer #(
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       req_valid,
  input  logic       req_dma,
  output logic       req_ready,
  input  logic       iordy,
  output logic       strobe_n,
  output logic       done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] SP_BASE = CNT_W'(5);
  localparam logic [CNT_W-1:0] RC_BASE = CNT_W'(4);

  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_REC} st_t;

  st_t              st;
  logic [7:0]       cfg_q;
  logic [1:0]       rdy_sync;
  logic [CNT_W-1:0] cnt, s_lim, r_lim;
  logic             fast_q, strobe_q, done_q;

  wire [CNT_W-1:0] s_new    = SP_BASE - CNT_W'(cfg_q[1:0]);
  wire [CNT_W-1:0] r_new    = RC_BASE - CNT_W'(cfg_q[3:2]);
  wire             fast_new = cfg_q[4] & (req_dma | ~cfg_q[5]);
  wire             rec_over = (st == ST_REC) && (cnt >= r_lim);
  wire             accept   = req_valid & req_ready;
  wire             release_now = (st == ST_ACT) && (cnt >= s_lim) && (fast_q || rdy_sync[1]);

  assign req_ready = (st == ST_IDLE) || rec_over;
  assign cfg_rdata = cfg_q;
  assign strobe_n  = strobe_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      rdy_sync <= '0;
      st       <= ST_IDLE;
      cnt      <= '0;
      s_lim    <= SP_BASE;
      r_lim    <= RC_BASE;
      fast_q   <= 1'b0;
      strobe_q <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata & 8'h3F;
      rdy_sync <= {rdy_sync[0], iordy};
      done_q   <= 1'b0;
      if (accept) begin
        st       <= ST_ACT;
        cnt      <= CNT_W'(1);
        s_lim    <= s_new;
        r_lim    <= r_new;
        fast_q   <= fast_new;
        strobe_q <= 1'b0;
      end else begin
        case (st)
          ST_ACT: begin
            if (release_now) begin
              st       <= ST_REC;
              cnt      <= CNT_W'(1);
              strobe_q <= 1'b1;
              done_q   <= 1'b1;
            end else if (cnt != CNT_MAX) begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_REC: begin
            if (rec_over) st <= ST_IDLE;
            else          cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module ide_strobe_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic strobe_n,
  input logic done
);
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !strobe_n);
  p_min_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |=> !strobe_n);
  p_fall_needs_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> $past(req_valid && req_ready));
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> !req_ready);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_at_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n) |-> done);
  p_done_strobe_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> strobe_n);
endmodule

bind ide_strobe_timer ide_strobe_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .strobe_n(strobe_n), .done(done)
);

// File: tb/ide_strobe_timer_tb.sv
module ide_strobe_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, req_valid = 1'b0, req_dma = 1'b0, iordy = 1'b1;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic req_ready, strobe_n, done;
  int n_chk = 0, n_bad = 0;
  logic [7:0] model_cfg = '0;

  always #4 clk = ~clk;

  ide_strobe_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_dma(req_dma),
    .req_ready(req_ready), .iordy(iordy), .strobe_n(strobe_n), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_s(input logic [7:0] c);
    return 5 - int'(c[1:0]);
  endfunction
  function automatic int exp_r(input logic [7:0] c);
    return 4 - int'(c[3:2]);
  endfunction
  function automatic bit exp_fast(input logic [7:0] c, input bit dma);
    return c[4] && (dma || !c[5]);
  endfunction
  function automatic int exp_width(input logic [7:0] c, input bit dma, input int k);
    int s = exp_s(c);
    if (exp_fast(c, dma) || k < 0) return s;
    return (k + 3 > s) ? k + 3 : s;
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    model_cfg = v & 8'h3F;
    check(cfg_rdata == model_cfg, "R2 readback", cfg_rdata, model_cfg);
  endtask

  // wr: 0 none, 1 write on accepting edge, 2 write mid-strobe; k<0 keeps iordy high
  task automatic xfer(input bit dma, input int k, input int wr, input logic [7:0] wv, input bit poke);
    int w, rr, guard, ew, er;
    logic [7:0] used;
    iordy = (k < 0);
    repeat (3) @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 20) begin @(negedge clk); guard++; end
    used = model_cfg;
    ew = exp_width(used, dma, k);
    er = exp_r(used);
    req_valid = 1'b1; req_dma = dma;
    if (wr == 1) begin cfg_we = 1'b1; cfg_wdata = wv; end
    @(negedge clk);
    req_valid = 1'b0;
    if (wr == 1) begin cfg_we = 1'b0; model_cfg = wv & 8'h3F; end
    w = 0;
    for (int i = 0; i < 40; i++) begin
      if (i == 2 && wr == 2) begin cfg_we = 1'b0; model_cfg = wv & 8'h3F; end
      if (i == 1 && wr == 2) begin cfg_we = 1'b1; cfg_wdata = wv; end
      if (i == k) iordy = 1'b1;
      if (strobe_n) break;
      w++;
      @(negedge clk);
    end
    if (wr == 2 && w < 2) begin cfg_we = 1'b0; model_cfg = wv & 8'h3F; end
    check(w == ew, exp_fast(used, dma) ? "R5/R6 fast width" : "R3/R4/R6 compat width", w, ew);
    check(done == 1'b1, "R8 done at release", done, 1);
    rr = 0;
    for (int j = 0; j < 8; j++) begin
      if (rr == 0 && req_ready) rr = j + 1;
      if (j == 1) check(done == 1'b0, "R8 done single", done, 0);
      if (poke && j >= 2) check(strobe_n && !done, "R10 ignored request", strobe_n, 1);
      if (poke && j == 1) req_valid = 1'b1;
      if (poke && j == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    check(rr == er, "R7 recovery", rr, er);
    if (wr != 0) check(cfg_rdata == model_cfg, "R9 new value visible", cfg_rdata, model_cfg);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(strobe_n == 1'b1, "R1 strobe idle", strobe_n, 1);
    check(done == 1'b0, "R1 done idle", done, 0);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(cfg_rdata == 8'h00, "R1 cfg reset", cfg_rdata, 0);
    xfer(1'b0, -1, 0, 8'h00, 1'b0);      // R1 defaults: 5 / 4
    xfer(1'b1, 4, 0, 8'h00, 1'b0);       // R4 stretch
    write_cfg(8'hFF);                    // R2 reserved bits
    for (int c = 0; c < 4; c++) begin
      write_cfg(8'(c * 5));              // R3/R7 each code, compat
      xfer(1'b0, 0, 0, 8'h00, 1'b0);
      xfer(1'b0, 6, 0, 8'h00, 1'b0);
    end
    write_cfg(8'h30);                    // R6 dma only
    xfer(1'b1, 9, 0, 8'h00, 1'b0);
    xfer(1'b0, 9, 0, 8'h00, 1'b0);
    write_cfg(8'h11);                    // R6 both fast
    xfer(1'b0, 9, 0, 8'h00, 1'b0);
    write_cfg(8'h01);                    // R6 fast disabled
    xfer(1'b1, 9, 0, 8'h00, 1'b0);
    xfer(1'b0, 0, 1, 8'h1F, 1'b0);       // R9 same-cycle write
    xfer(1'b0, 7, 0, 8'h00, 1'b0);
    xfer(1'b1, 5, 2, 8'h00, 1'b0);       // R9 mid-strobe write
    xfer(1'b1, -1, 0, 8'h00, 1'b1);      // R10 poke during recovery
    for (int n = 0; n < 180; n++) begin
      int kk = int'($urandom_range(0, 9)) - 1;
      int wr = int'($urandom_range(0, 3));
      logic [7:0] v = 8'($urandom);
      if (wr == 3) begin write_cfg(v); wr = 0; end
      xfer(1'($urandom), kk, wr, 8'($urandom), (exp_r(model_cfg) >= 3) && ($urandom_range(0, 3) == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule